// File: doc/BRIEF.md
# Programmable NAND Bus Cycle Sequencer

This block turns single register-side requests into timed cycles on an 8-bit asynchronous NAND flash bus. A request is a command byte, an address byte, a data byte to write, or a data read. Each accepted request becomes one bus cycle with three phases: setup, strobe-active and hold. After the hold phase comes an optional wait, at the end of which the device ready pin is sampled.

Every phase length comes from one packed 32-bit timing word. The word holds separate setup, strobe-width, hold and ready-wait counts for reads and for writes, at fixed nibble positions. The sequencer copies the whole word when it accepts a request, so software can reprogram the timing while a cycle is running. While a cycle is in progress the block raises a busy flag and ignores new requests. A separate input can hold chip enable low between cycles, so that multi-cycle device operations are not broken up.

Top module: `nand_cycle_seq`

## Requirements
- R1: `busy_o` rises on the clock edge that accepts a request and stays high until the ready-wait phase ends. A request is accepted only when `req_valid_i` is high and `busy_o` is low.
- R2: Every cycle runs its phases in this order: setup, strobe-active, hold, then the ready wait. The write strobe (`nand_we_n_o` low, for command, address and data-write cycles) or the read strobe (`nand_re_n_o` low, for read cycles) is active only in the strobe-active phase, and both are never active at once.
- R3: A field value n gives n+1 clocks for the setup, strobe-active and hold phases. Read cycles use bits [3:0] for setup, [7:4] for hold and [11:8] for width. All other cycles use bits [19:16] for setup, [23:20] for hold and [27:24] for width.
- R4: The ready wait lasts 2*n clocks, with n taken from bits [15:12] for reads and bits [31:28] for the other cycles. When the wait ends, `nand_rdy_i` is captured into `rdy_o`. When n is 0, the capture happens at the end of the hold phase.
- R5: `req_kind_i` = 0 (command) asserts `nand_cle_o` from setup through hold, with the byte on `nand_dq_o`.
- R6: `req_kind_i` = 1 (address) asserts `nand_ale_o` from setup through hold, with the byte on `nand_dq_o`.
- R7: `req_kind_i` = 2 (data write) and cycle kinds 0 and 1 drive `nand_dq_oe_o` high and present the request byte on `nand_dq_o` from setup through hold. `req_kind_i` = 3 (data read) never drives the bus.
- R8: On a read, `nand_dq_i` is captured into `rd_data_o` on the clock edge that ends the strobe-active phase. The value is held until the next read.
- R9: Outside the force window, `nand_ce_n_o` is low only during setup, strobe-active and hold.
- R10: While `force_ce_i` is high, `nand_ce_n_o` is low in every clock, including idle and wait.
- R11: Changes to `timing_i` after a request has been accepted do not affect that cycle.
- R12: After reset, `busy_o` = 0, all strobes and latch enables are inactive, `nand_dq_oe_o` = 0, and `rd_data_o` = 0 and `rdy_o` = 0.
- R13: A request presented while `busy_o` is high is ignored. Its kind and data never reach the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_i | input | 32 | Packed timing word |
| force_ce_i | input | 1 | Hold chip enable low |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data_i | input | 8 | Byte for command, address or write |
| busy_o | output | 1 | Cycle in progress |
| rd_data_o | output | 8 | Last byte read |
| rdy_o | output | 1 | Last sampled ready level |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus output data |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus input data |
| nand_rdy_i | input | 1 | Device ready pin |

## Verification
The bench covers the following corner cases:
- **Timing extremes.** All-zero and all-fifteen timing words exercise one-clock phases and sixteen-clock phases. A counter off by one would stretch or shrink every strobe.
- **Zero ready wait.** This case checks that `rdy_o` is captured at the end of hold. A design that enters the wait phase anyway would hold busy one clock too long, or miss the capture.
- **Timing changes mid-cycle.** The timing word is rescrambled on every busy clock. A design that reads the live word would change phase lengths partway through a cycle.
- **Requests while busy.** Requests are held valid with new data while busy. A design without the stall would corrupt the bus byte or the cycle kind.
- **Force toggling.** `force_ce_i` is toggled at random, which exposes chip enable being tied to the cycle state alone.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_WAIT   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } op_e;

endpackage

// File: rtl/nand_tim_sel.sv
module nand_tim_sel #(
    parameter int FIELD_W = 4
) (
    input  logic [8*FIELD_W-1:0] tim_i,
    input  logic                 is_read_i,
    output logic [FIELD_W-1:0]   setup_o,
    output logic [FIELD_W-1:0]   hold_o,
    output logic [FIELD_W-1:0]   width_o,
    output logic [FIELD_W-1:0]   rwait_o
);
    localparam int HALF_W = 4 * FIELD_W;

    logic [HALF_W-1:0] half;

    always_comb begin
        half    = is_read_i ? tim_i[HALF_W-1:0] : tim_i[2*HALF_W-1:HALF_W];
        setup_o = half[0*FIELD_W +: FIELD_W];
        hold_o  = half[1*FIELD_W +: FIELD_W];
        width_o = half[2*FIELD_W +: FIELD_W];
        rwait_o = half[3*FIELD_W +: FIELD_W];
    end

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  op_e                  op_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [8*FIELD_W-1:0] tim_i,
    input  logic [DATA_W-1:0]    dq_i,
    input  logic                 rdy_i,
    output phase_e               phase_o,
    output op_e                  op_o,
    output logic [DATA_W-1:0]    wdata_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 rdy_o
);
    localparam int CNT_W = FIELD_W + 1;
    localparam int TIM_W = 8 * FIELD_W;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        op_e                 op;
        logic [DATA_W-1:0]   wdata;
        logic [TIM_W-1:0]    tim;
        logic [DATA_W-1:0]   rdata;
        logic                rdy;
    } st_t;

    st_t st_d, st_q;

    logic [FIELD_W-1:0] setup_n, hold_n, width_n, rwait_n;
    logic [CNT_W-1:0]   wait_last;

    nand_tim_sel #(.FIELD_W(FIELD_W)) u_sel (
        .tim_i     (st_q.tim),
        .is_read_i (st_q.op == OP_RD),
        .setup_o   (setup_n),
        .hold_o    (hold_n),
        .width_o   (width_n),
        .rwait_o   (rwait_n)
    );

    assign wait_last = {rwait_n, 1'b0} - CNT_W'(1);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = '0;
                    st_d.op    = op_i;
                    st_d.wdata = wdata_i;
                    st_d.tim   = tim_i;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == CNT_W'(setup_n)) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt == CNT_W'(width_n)) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = '0;
                    if (st_q.op == OP_RD) st_d.rdata = dq_i;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == CNT_W'(hold_n)) begin
                    st_d.cnt = '0;
                    if (rwait_n == '0) begin
                        st_d.phase = PH_IDLE;
                        st_d.rdy   = rdy_i;
                    end else begin
                        st_d.phase = PH_WAIT;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == wait_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.rdy   = rdy_i;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, op: OP_CMD, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign op_o    = st_q.op;
    assign wdata_o = st_q.wdata;
    assign rdata_o = st_q.rdata;
    assign rdy_o   = st_q.rdy;

    // R11: latched cycle parameters do not move while a cycle runs
    p_latched_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && st_d.phase != PH_IDLE) |=>
            ($stable(st_q.tim) && $stable(st_q.op) && $stable(st_q.wdata)));

    // R3: phase counters stay within their programmed length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SETUP)  |-> (st_q.cnt <= CNT_W'(setup_n)));

    // R2: setup is always followed by strobe-active
    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SETUP && st_d.phase != PH_SETUP) |=> (st_q.phase == PH_ACTIVE));

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [8*FIELD_W-1:0] timing_i,
    input  logic                 force_ce_i,
    input  logic                 req_valid_i,
    input  logic [1:0]           req_kind_i,
    input  logic [DATA_W-1:0]    req_data_i,
    output logic                 busy_o,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 rdy_o,
    output logic                 nand_ce_n_o,
    output logic                 nand_cle_o,
    output logic                 nand_ale_o,
    output logic                 nand_we_n_o,
    output logic                 nand_re_n_o,
    output logic [DATA_W-1:0]    nand_dq_o,
    output logic                 nand_dq_oe_o,
    input  logic [DATA_W-1:0]    nand_dq_i,
    input  logic                 nand_rdy_i
);
    phase_e phase;
    op_e    op_q;
    logic   in_cyc;
    logic   strobe;

    nand_seq_fsm #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (req_valid_i),
        .op_i    (op_e'(req_kind_i)),
        .wdata_i (req_data_i),
        .tim_i   (timing_i),
        .dq_i    (nand_dq_i),
        .rdy_i   (nand_rdy_i),
        .phase_o (phase),
        .op_o    (op_q),
        .wdata_o (nand_dq_o),
        .rdata_o (rd_data_o),
        .rdy_o   (rdy_o)
    );

    always_comb begin
        in_cyc       = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
        strobe       = (phase == PH_ACTIVE);
        busy_o       = (phase != PH_IDLE);
        nand_ce_n_o  = !(force_ce_i || in_cyc);
        nand_cle_o   = in_cyc && (op_q == OP_CMD);
        nand_ale_o   = in_cyc && (op_q == OP_ADDR);
        nand_we_n_o  = !(strobe && (op_q != OP_RD));
        nand_re_n_o  = !(strobe && (op_q == OP_RD));
        nand_dq_oe_o = in_cyc && (op_q != OP_RD);
    end

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n_o && !nand_re_n_o));

    p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle_o && nand_ale_o));

    p_strobe_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n_o || !nand_re_n_o) |-> busy_o);

    p_ce_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_ce_i && !busy_o) |-> nand_ce_n_o);

    p_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_dq_oe_o && !nand_re_n_o));

endmodule

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_i = '0;
    logic        force_ce_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_kind_i = '0;
    logic [7:0]  req_data_i = '0;
    logic        busy_o;
    logic [7:0]  rd_data_o;
    logic        rdy_o;
    logic        nand_ce_n_o, nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rdy_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nand_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .timing_i(timing_i), .force_ce_i(force_ce_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_data_i(req_data_i),
        .busy_o(busy_o), .rd_data_o(rd_data_o), .rdy_o(rdy_o),
        .nand_ce_n_o(nand_ce_n_o), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
        .nand_we_n_o(nand_we_n_o), .nand_re_n_o(nand_re_n_o), .nand_dq_o(nand_dq_o),
        .nand_dq_oe_o(nand_dq_oe_o), .nand_dq_i(nand_dq_i), .nand_rdy_i(nand_rdy_i)
    );

    // Reference model: queue of phase codes, 1 setup 2 active 3 hold 4 wait
    int       ph_q[$];
    int       m_kind = 0;
    int       m_wd = 0;
    int       m_rd = 0;
    int       m_rdy = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph_q.delete();
            m_rd = 0;
            m_rdy = 0;
        end else if (ph_q.size() != 0) begin
            int p;
            p = ph_q.pop_front();
            if (p == 2 && m_kind == 3 && (ph_q.size() == 0 || ph_q[0] != 2)) m_rd = int'(nand_dq_i);
            if (ph_q.size() == 0) m_rdy = int'(nand_rdy_i);
        end else if (req_valid_i) begin
            int b;
            m_kind = int'(req_kind_i);
            m_wd   = int'(req_data_i);
            b      = (m_kind == 3) ? 0 : 16;
            for (int i = 0; i <= int'(timing_i[b +: 4]); i++)      ph_q.push_back(1);
            for (int i = 0; i <= int'(timing_i[b+8 +: 4]); i++)    ph_q.push_back(2);
            for (int i = 0; i <= int'(timing_i[b+4 +: 4]); i++)    ph_q.push_back(3);
            for (int i = 0; i < 2*int'(timing_i[b+12 +: 4]); i++)  ph_q.push_back(4);
        end
    end

    task automatic cmp(input string req, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, nm, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        int ph;
        bit cyc;
        ph  = (ph_q.size() != 0) ? ph_q[0] : 0;
        cyc = (ph >= 1 && ph <= 3);
        cmp("R1",  "busy",  int'(busy_o),      int'(ph_q.size() != 0));
        cmp("R10", "ce_n",  int'(nand_ce_n_o), int'(!(force_ce_i || cyc)));
        cmp("R5",  "cle",   int'(nand_cle_o),  int'(cyc && m_kind == 0));
        cmp("R6",  "ale",   int'(nand_ale_o),  int'(cyc && m_kind == 1));
        cmp("R3",  "we_n",  int'(nand_we_n_o), int'(!(ph == 2 && m_kind != 3)));
        cmp("R2",  "re_n",  int'(nand_re_n_o), int'(!(ph == 2 && m_kind == 3)));
        cmp("R7",  "oe",    int'(nand_dq_oe_o), int'(cyc && m_kind != 3));
        if (cyc && m_kind != 3) cmp("R13", "dq", int'(nand_dq_o), m_wd);
        cmp("R8",  "rd_data", int'(rd_data_o), m_rd);
        cmp("R4",  "rdy",   int'(rdy_o),       m_rdy);
    endtask

    function automatic logic [31:0] pick_timing(input int idx);
        case (idx % 5)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return {4'h0, $urandom_range(0, 15 * 16 * 16 * 16 - 1) % 4096, 4'h0, 12'h000} | 32'h0000_0321;
            3: return $urandom() & 32'h0FFF_0FFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin : watchdog
        while (cycles < 150000) @(posedge clk) cycles++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : drive
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        cmp("R12", "busy", int'(busy_o), 0);
        cmp("R12", "strobes", int'({nand_we_n_o, nand_re_n_o, nand_cle_o, nand_ale_o, nand_dq_oe_o, nand_ce_n_o}), 6'b110001);
        cmp("R12", "rd_data", int'(rd_data_o), 0);
        cmp("R12", "rdy", int'(rdy_o), 0);
        for (int r = 0; r < 90; r++) begin
            while (ph_q.size() != 0) begin
                compare_all();
                // R11: scramble timing while busy; R13: ignored requests while busy
                timing_i    = $urandom();
                req_valid_i = ($urandom_range(0, 2) == 0);
                req_kind_i  = 2'($urandom_range(0, 3));
                req_data_i  = 8'($urandom());
                nand_dq_i   = 8'($urandom());
                nand_rdy_i  = 1'($urandom());
                force_ce_i  = (r % 7 == 3) ? 1'b1 : ($urandom_range(0, 9) == 0);
                @(negedge clk);
            end
            compare_all();
            req_valid_i = 1'b1;
            req_kind_i  = 2'(r % 4);
            req_data_i  = 8'($urandom());
            timing_i    = pick_timing(r);
            nand_dq_i   = 8'($urandom());
            nand_rdy_i  = 1'($urandom());
            force_ce_i  = (r % 7 == 3);
            @(negedge clk);
        end
        while (ph_q.size() != 0) begin
            compare_all();
            req_valid_i = 1'b0;
            @(negedge clk);
        end
        compare_all();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule